// File: doc/BRIEF.md
# PHY Trim Parameter Loader

This block is a hardware sequencer that programs trim and tuning fields into a PHY's internal register file after the link reset is released. The register file sits behind a narrow test port. The loader drives one registered command word out and takes one readback byte back in. It performs a read-modify-write for each entry of a parameter table. Each entry names a register address, a bit range given as MSB and LSB, and a field value.

For each entry the loader reads the register and merges the new field into the byte it read. It writes the result back with a three-word strobe frame, then reads the same register again and discards the result. Every command word stays on the port for one issue cycle plus a fixed number of readback sample cycles. A bypass input makes a start pulse skip all programming and report completion at once. This serves PHY variants that need no trimming.

Top module: `ptl_loader`

## Requirements
- R1: The command word `cmd_o` carries the data field in bits 13:6, the register address in bits 5:1 and the write strobe in bit 0. It is all zeros whenever the loader is not busy, including after reset.
- R2: Every command word stays unchanged on `cmd_o` for WAIT_CYC+1 cycles (3 by default): one issue cycle and two readback sample cycles. A read result is taken from `rdbk_i` in the last of these cycles.
- R3: A register read is the word with data field 1, the entry's address and strobe 0. The loader captures the byte on `rdbk_i` at the end of that word's hold time.
- R4: A write is three successive words with the same data and address. The strobe is 0 in the first, 1 in the second and 0 in the third. Exactly one strobe rising edge occurs per programmed entry.
- R5: Each write is followed by a read word for the same register. Its result has no effect on any register.
- R6: The field mask covers bits LSB through MSB. The written byte is (readback AND NOT mask) OR ((value << LSB) AND mask), so the bits outside the mask keep the values read back. If MSB < LSB the mask is empty and the register is rewritten unchanged.
- R7: A start with `bypass_i` high issues no command. `done_o` is high in the cycle after the start edge.
- R8: Entry k sits in `table_i[k*19 +: 19]` as {value[7:0], msb[2:0], lsb[2:0], addr[4:0]}. Entries are applied in index order 0..N-1. N is `count_i` clamped to MAX_ENT (7), and a count of 0 gives immediate done.
- R9: With N entries, `busy_o` is high from the start edge on. `done_o` rises 15*N clock edges after the start edge. `done_o` then stays high until the next accepted start.
- R10: A start pulse while `busy_o` is high is ignored: the run in progress, its timing and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while not busy |
| bypass_i | input | 1 | Skip programming and finish at once |
| count_i | input | 4 | Number of table entries to apply |
| table_i | input | 133 | Parameter table, 7 entries of 19 bits |
| rdbk_i | input | 8 | Readback byte from the test port |
| cmd_o | output | 14 | Test-port command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until next start |

## Verification
Every command word is registered and loaded on a clock edge. The checks therefore count edges from the edge that samples the start. The read word appears just after that edge. The write-data word follows 3 edges later, the strobe word after 6, the clearing word after 9 and the dummy read after 12. Done is due exactly 15*N edges after the start edge, or one edge after it for bypass and zero count. The bench drives inputs and samples outputs on falling edges. It checks done low one edge before it is due and high on the due edge. Register contents are compared after the run against a model that applies the entries in order.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } ptl_state_e;

   typedef enum logic [2:0] {
      PH_RD = 3'd0,
      PH_WD = 3'd1,
      PH_WS = 3'd2,
      PH_WC = 3'd3,
      PH_DM = 3'd4
   } ptl_phase_e;

   localparam int PTL_PHASES = 5;

endpackage

// File: rtl/ptl_entry_sel.sv
module ptl_entry_sel #(
   parameter int MAX_ENT = 7,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 8,
   parameter int POS_W   = 3,
   parameter int IDX_W   = 3,
   parameter int ENT_W   = 19
) (
   input  logic [MAX_ENT*ENT_W-1:0] table_i,
   input  logic [IDX_W-1:0]         idx_i,
   output logic [ADDR_W-1:0]        addr_o,
   output logic [POS_W-1:0]         msb_o,
   output logic [POS_W-1:0]         lsb_o,
   output logic [DATA_W-1:0]        val_o
);

   if (ENT_W != ADDR_W + 2*POS_W + DATA_W) begin : g_bad_ent
      $error("ptl_entry_sel: ENT_W does not match field widths");
   end

   logic [ENT_W-1:0] ent_a [MAX_ENT];
   logic [ENT_W-1:0] pick;

   for (genvar g = 0; g < MAX_ENT; g++) begin : g_slice
      assign ent_a[g] = table_i[g*ENT_W +: ENT_W];
   end

   always_comb begin
      pick = '0;
      for (int k = 0; k < MAX_ENT; k++) begin
         if (idx_i == IDX_W'(k)) pick = ent_a[k];
      end
   end

   assign addr_o = pick[ADDR_W-1:0];
   assign lsb_o  = pick[ADDR_W +: POS_W];
   assign msb_o  = pick[ADDR_W+POS_W +: POS_W];
   assign val_o  = pick[ADDR_W+2*POS_W +: DATA_W];

endmodule

// File: rtl/ptl_field_merge.sv
module ptl_field_merge #(
   parameter int DATA_W = 8,
   parameter int POS_W  = 3
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic [POS_W-1:0]  msb_i,
   input  logic [POS_W-1:0]  lsb_i,
   output logic [DATA_W-1:0] new_o
);

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] shifted;

   // one comparator pair per bit position
   for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      assign mask[b] = (b >= int'(lsb_i)) && (b <= int'(msb_i));
   end

   assign shifted = val_i << lsb_i;
   assign new_o   = (old_i & ~mask) | (shifted & mask);

endmodule

// File: rtl/ptl_seq.sv
module ptl_seq
   import ptl_pkg::*;
#(
   parameter int MAX_ENT  = 7,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 4,
   parameter int IDX_W    = 3,
   parameter int WAIT_CYC = 2,
   parameter int CMD_W    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bypass_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] merged_i,
   output logic [IDX_W-1:0]  sel_idx_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int WC_W = $clog2(WAIT_CYC + 1);

   ptl_state_e        state_q;
   ptl_phase_e        phase_q;
   logic [WC_W-1:0]   wcnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  num_q;
   logic [CMD_W-1:0]  cmd_q;
   logic              done_q;

   logic [IDX_W-1:0]  lim;
   logic              phase_end;
   logic              last_ent;
   logic [CMD_W-1:0]  rd_word;

   always_comb begin
      if (count_i > CNT_W'(MAX_ENT)) lim = IDX_W'(MAX_ENT);
      else                           lim = count_i[IDX_W-1:0];
   end

   assign phase_end = (wcnt_q == WC_W'(WAIT_CYC));
   assign last_ent  = (idx_q == num_q - 1'b1);
   assign rd_word   = {DATA_W'(1), addr_i, 1'b0};

   // index look-ahead so the next read word carries the next address
   always_comb begin
      if (state_q != ST_RUN)                    sel_idx_o = '0;
      else if (phase_q == PH_DM && phase_end)   sel_idx_o = idx_q + 1'b1;
      else                                      sel_idx_o = idx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_RD;
         wcnt_q  <= '0;
         idx_q   <= '0;
         num_q   <= '0;
         cmd_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  if (bypass_i || lim == '0) begin
                     state_q <= ST_DONE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                     done_q  <= 1'b0;
                     num_q   <= lim;
                     idx_q   <= '0;
                     phase_q <= PH_RD;
                     wcnt_q  <= '0;
                     cmd_q   <= rd_word;
                  end
               end
            end
            ST_RUN: begin
               if (!phase_end) begin
                  wcnt_q <= wcnt_q + 1'b1;
               end else begin
                  wcnt_q <= '0;
                  case (phase_q)
                     PH_RD: begin
                        phase_q <= PH_WD;
                        cmd_q   <= {merged_i, addr_i, 1'b0};
                     end
                     PH_WD: begin
                        phase_q  <= PH_WS;
                        cmd_q[0] <= 1'b1;
                     end
                     PH_WS: begin
                        phase_q  <= PH_WC;
                        cmd_q[0] <= 1'b0;
                     end
                     PH_WC: begin
                        phase_q <= PH_DM;
                        cmd_q   <= rd_word;
                     end
                     default: begin
                        if (last_ent) begin
                           state_q <= ST_DONE;
                           done_q  <= 1'b1;
                           cmd_q   <= '0;
                           phase_q <= PH_RD;
                        end else begin
                           idx_q   <= idx_q + 1'b1;
                           phase_q <= PH_RD;
                           cmd_q   <= rd_word;
                        end
                     end
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_o  = cmd_q;
   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;

endmodule

// File: rtl/ptl_loader.sv
module ptl_loader #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 5,
   parameter int MAX_ENT  = 7,
   parameter int CNT_W    = 4,
   parameter int WAIT_CYC = 2,
   parameter int POS_W    = $clog2(DATA_W),
   parameter int ENT_W    = ADDR_W + 2*POS_W + DATA_W,
   parameter int CMD_W    = DATA_W + ADDR_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      bypass_i,
   input  logic [CNT_W-1:0]          count_i,
   input  logic [MAX_ENT*ENT_W-1:0]  table_i,
   input  logic [DATA_W-1:0]         rdbk_i,
   output logic [CMD_W-1:0]          cmd_o,
   output logic                      busy_o,
   output logic                      done_o
);

   localparam int IDX_W = $clog2(MAX_ENT + 1);

   if (DATA_W < 2) begin : g_bad_dw
      $error("ptl_loader: DATA_W must be at least 2");
   end
   if (MAX_ENT < 1) begin : g_bad_ent
      $error("ptl_loader: MAX_ENT must be at least 1");
   end
   if (CNT_W < IDX_W) begin : g_bad_cnt
      $error("ptl_loader: CNT_W too narrow for MAX_ENT");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("ptl_loader: WAIT_CYC must be at least 1");
   end
   if (CMD_W != DATA_W + ADDR_W + 1) begin : g_bad_cmd
      $error("ptl_loader: CMD_W inconsistent");
   end

   logic [IDX_W-1:0]  sel_idx;
   logic [ADDR_W-1:0] ent_addr;
   logic [POS_W-1:0]  ent_msb;
   logic [POS_W-1:0]  ent_lsb;
   logic [DATA_W-1:0] ent_val;
   logic [DATA_W-1:0] merged;

   ptl_entry_sel #(
      .MAX_ENT(MAX_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .POS_W(POS_W), .IDX_W(IDX_W), .ENT_W(ENT_W)
   ) u_sel (
      .table_i (table_i),
      .idx_i   (sel_idx),
      .addr_o  (ent_addr),
      .msb_o   (ent_msb),
      .lsb_o   (ent_lsb),
      .val_o   (ent_val)
   );

   ptl_field_merge #(
      .DATA_W(DATA_W), .POS_W(POS_W)
   ) u_merge (
      .old_i (rdbk_i),
      .val_i (ent_val),
      .msb_i (ent_msb),
      .lsb_i (ent_lsb),
      .new_o (merged)
   );

   ptl_seq #(
      .MAX_ENT(MAX_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .IDX_W(IDX_W), .WAIT_CYC(WAIT_CYC), .CMD_W(CMD_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .bypass_i  (bypass_i),
      .count_i   (count_i),
      .addr_i    (ent_addr),
      .merged_i  (merged),
      .sel_idx_o (sel_idx),
      .cmd_o     (cmd_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

endmodule

// File: rtl/ptl_loader_chk.sv
module ptl_loader_chk #(
   parameter int CMD_W    = 14,
   parameter int WAIT_CYC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             bypass_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [CMD_W-1:0] cmd_o
);

   localparam int HC_W = $clog2(WAIT_CYC + 2) + 1;

   logic [CMD_W-1:0] prev_q;
   logic [HC_W-1:0]  same_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         same_q <= '0;
      end else begin
         prev_q <= cmd_o;
         if (cmd_o != prev_q)   same_q <= '0;
         else if (same_q != '1) same_q <= same_q + 1'b1;
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != prev_q && prev_q != '0) |-> same_q >= HC_W'(WAIT_CYC)); // R2

   AST_STROBE_RISE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_o[0]) |-> cmd_o[CMD_W-1:1] == $past(cmd_o[CMD_W-1:1])); // R4

   AST_STROBE_FALL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_o[0]) |-> cmd_o[CMD_W-1:1] == $past(cmd_o[CMD_W-1:1])); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cmd_o == '0); // R1

   AST_BYPASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && bypass_i && !busy_o) |=> (done_o && !busy_o)); // R7

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o); // R9

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o)); // R9

   AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && cmd_o[0]) |=> busy_o); // R10

endmodule

bind ptl_loader ptl_loader_chk #(
   .CMD_W(CMD_W), .WAIT_CYC(WAIT_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .bypass_i (bypass_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .cmd_o    (cmd_o)
);

// File: tb/ptl_loader_bench.sv
module ptl_loader_bench;

   localparam int DW   = 8;
   localparam int AW   = 5;
   localparam int ME   = 7;
   localparam int CW   = 4;
   localparam int WT   = 2;
   localparam int BW   = 3;
   localparam int EW   = AW + 2*BW + DW;
   localparam int CMDW = DW + AW + 1;
   localparam int HOLD = WT + 1;
   localparam int PER  = HOLD * 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            bypass = 1'b0;
   logic [CW-1:0]   count = '0;
   logic [ME*EW-1:0] tbl = '0;
   logic [DW-1:0]   rdbk;
   logic [CMDW-1:0] cmd;
   logic            busy;
   logic            done;

   int checks = 0;
   int errs   = 0;

   always #5 clk = ~clk;

   ptl_loader u_ptl_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .bypass_i (bypass),
      .count_i  (count),
      .table_i  (tbl),
      .rdbk_i   (rdbk),
      .cmd_o    (cmd),
      .busy_o   (busy),
      .done_o   (done)
   );

   // behavioural PHY register file
   logic [DW-1:0] mem [32];
   logic          we_q = 1'b0;
   logic          pre_en = 1'b0;
   logic [AW-1:0] pre_a = '0;
   logic [DW-1:0] pre_d = '0;
   int            stb_cnt = 0;

   always @(posedge clk) begin
      if (pre_en) mem[pre_a] <= pre_d;
      else if (cmd[0] && !we_q) begin
         mem[cmd[AW:1]] <= cmd[CMDW-1:AW+1];
         stb_cnt <= stb_cnt + 1;
      end
      we_q <= cmd[0];
      rdbk <= mem[cmd[AW:1]];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input int d);
      pre_en = 1'b1;
      pre_a  = AW'(a);
      pre_d  = DW'(d);
      @(negedge clk);
      pre_en = 1'b0;
   endtask

   function automatic logic [EW-1:0] ent(input int a, input int msb, input int lsb, input int v);
      return {DW'(v), BW'(msb), BW'(lsb), AW'(a)};
   endfunction

   function automatic logic [DW-1:0] exp_merge(input logic [DW-1:0] old, input int msb,
                                               input int lsb, input logic [DW-1:0] v);
      logic [DW-1:0] r;
      r = old;
      for (int b = 0; b < DW; b++) begin
         if (b >= lsb && b <= msb) r[b] = v[b-lsb];
      end
      return r;
   endfunction

   task automatic go(input int n_req, input bit mid, input bit words, input string req);
      int n;
      int s0;
      int mism;
      logic [DW-1:0]   shadow [32];
      logic [EW-1:0]   e;
      logic [CMDW-1:0] w_rd;
      logic [CMDW-1:0] w_wd;
      n = bypass ? 0 : ((n_req > ME) ? ME : n_req);
      s0 = stb_cnt;
      for (int a = 0; a < 32; a++) shadow[a] = mem[a];
      e = tbl[EW-1:0];
      w_rd = {DW'(1), e[AW-1:0], 1'b0};
      w_wd = {exp_merge(mem[e[AW-1:0]], int'(e[AW+BW +: BW]), int'(e[AW +: BW]),
                        e[AW+2*BW +: DW]), e[AW-1:0], 1'b0};
      for (int i = 0; i < n; i++) begin
         e = tbl[i*EW +: EW];
         shadow[e[AW-1:0]] = exp_merge(shadow[e[AW-1:0]], int'(e[AW+BW +: BW]),
                                       int'(e[AW +: BW]), e[AW+2*BW +: DW]);
      end
      count = CW'(n_req);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         check({req, " R7/R8 immediate done"}, {31'd0, done}, 32'd1);
         check({req, " R1 no command"}, 32'(cmd), 32'd0);
      end else begin
         check({req, " R9 busy after start"}, {31'd0, busy}, 32'd1);
         if (words) check("R3 read word", 32'(cmd), 32'(w_rd));
      end
      for (int c = 1; c <= PER*n; c++) begin
         @(negedge clk);
         if (mid && c == 20) begin start = 1'b1; bypass = 1'b1; end
         else if (mid && c == 21) begin start = 1'b0; bypass = 1'b0; end
         if (words) begin
            if (c == WT)     check("R2 read word held", 32'(cmd), 32'(w_rd));
            if (c == HOLD)   check("R4 write data word", 32'(cmd), 32'(w_wd));
            if (c == 2*HOLD) check("R4 strobe word", 32'(cmd), 32'(w_wd | 1));
            if (c == 3*HOLD) check("R4 strobe clear word", 32'(cmd), 32'(w_wd));
            if (c == 4*HOLD) check("R5 dummy read word", 32'(cmd), 32'(w_rd));
         end
         if (c == PER*n - 1) check({req, " R9 done not early"}, {31'd0, done}, 32'd0);
         if (c == PER*n) begin
            check({req, " R9 done on time"}, {31'd0, done}, 32'd1);
            check({req, " R9 busy cleared"}, {31'd0, busy}, 32'd0);
         end
      end
      mism = 0;
      for (int a = 0; a < 32; a++) if (mem[a] !== shadow[a]) mism++;
      check({req, " register file contents"}, 32'(mism), 32'd0);
      check({req, " R4 strobe count"}, 32'(stb_cnt - s0), 32'(n));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL R9 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset cmd", 32'(cmd), 32'd0);
      check("R9 reset busy", {31'd0, busy}, 32'd0);
      check("R9 reset done", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 32; a++) poke(a, (a*37 + 11) & 255);

      // bypass: nothing programmed
      tbl[EW-1:0] = ent(4, 7, 0, 8'hA5);
      bypass = 1'b1;
      go(3, 1'b0, 1'b0, "R7 bypass");
      bypass = 1'b0;

      // zero count
      go(0, 1'b0, 1'b0, "R8 zero count");

      // command word sequence of one entry
      tbl[EW-1:0] = ent(5, 6, 2, 8'h2D);
      go(1, 1'b0, 1'b1, "R6 words");

      // sweep of every msb/lsb pair, including empty masks
      for (int l = 0; l < 8; l++) begin
         for (int m = 0; m < 8; m++) begin
            tbl[EW-1:0] = ent((l*8 + m) % 32, m, l, (l*31 + m*7 + 3) & 255);
            go(1, 1'b0, 1'b0, "R6 mask sweep");
         end
      end

      // full table, repeated register shows ordering
      tbl = {ent(9, 7, 4, 8'h0C), ent(3, 1, 0, 8'h01), ent(9, 3, 0, 8'h05),
             ent(20, 5, 5, 8'h01), ent(9, 6, 5, 8'h02), ent(3, 3, 0, 8'h03),
             ent(7, 3, 0, 8'h0A)};
      go(7, 1'b0, 1'b0, "R8 full table");

      // count above table size clamps
      tbl = {ent(11, 7, 0, 8'h11), ent(12, 7, 0, 8'h22), ent(13, 4, 1, 8'h0F),
             ent(11, 2, 1, 8'h03), ent(14, 7, 7, 8'h01), ent(15, 0, 0, 8'h00),
             ent(16, 5, 2, 8'h09)};
      go(12, 1'b0, 1'b0, "R8 clamp");

      // start during busy ignored
      tbl = {ent(0, 0, 0, 0), ent(0, 0, 0, 0), ent(0, 0, 0, 0),
             ent(21, 7, 0, 8'h5A), ent(22, 3, 2, 8'h02), ent(21, 1, 0, 8'h00),
             ent(23, 6, 1, 8'h3F)};
      go(4, 1'b1, 1'b0, "R10 start while busy");

      // done holds until next start
      repeat (10) @(negedge clk);
      check("R9 done held", {31'd0, done}, 32'd1);
      go(2, 1'b0, 1'b0, "R9 restart");

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule